// File: doc/BRIEF.md
# Serial-Loaded Cartridge Bank Controller

This block sits on an 8-bit game cartridge between the CPU bus, the PPU address bus and the program and character ROMs. Software sets it up through a single data line: each write anywhere in the upper half of the CPU address space shifts one bit, taken from data bit 0, into a small shift register. The fifth accepted bit completes a 5-bit value. That value lands in one of four internal registers, chosen by CPU address bits 14:13 of that final write. A write with data bit 7 set abandons a partial load and puts the program window back into a known layout.

The registers hold the nametable mirroring mode, the program window layout, two 4 KiB character bank numbers and one program bank number. From these, the block drives the upper ROM address lines for both buses, an enable for an 8 KiB work RAM at $6000-$7FFF, and the select line for the console's internal nametable RAM. The bus clock is one cycle per CPU cycle. A write strobe on the cycle right after an accepted write is dropped, so a read-modify-write instruction, which writes twice back to back, only delivers its first write.

Top module: `serial_bank_ctrl`

## Requirements
- R1: After reset the control register is 4'b1100: mirroring mode 0 (nametable select low), 16 KiB layout, last bank fixed at $C000. Both character banks and the program bank are 0.
- R2: A write with cpuAddrHi[2]=1 and cpuDataMsb=0 shifts cpuDataLsb in, least significant bit first. The fifth such write commits {that bit, the four earlier bits}. Writes with cpuAddrHi[2]=0 do not shift.
- R3: The committing write's cpuAddrHi[1:0] selects the target: 0 control, 1 character bank 0, 2 character bank 1, 3 program bank.
- R4: A mapper write with cpuDataMsb=1 discards the partial shift and clears the count. It sets control bits 3:2 to 2'b11 and keeps control bits 1:0.
- R5: A mapper write on the cycle directly after an accepted mapper write has no effect. This holds whether the accepted write was a shift or a reset.
- R6: With control bit 3 = 0, prgAddrHi = {program bank with bit 0 dropped, cpuAddrHi[1]}. This is a 32 KiB switch.
- R7: With control bits 3:2 = 2'b11, prgAddrHi is the program bank for cpuAddrHi[1]=0 and all ones for cpuAddrHi[1]=1.
- R8: With control bits 3:2 = 2'b10, prgAddrHi is 0 for cpuAddrHi[1]=0 and the program bank for cpuAddrHi[1]=1.
- R9: chrAddrHi equals character bank 0 when ppuA12=0 and character bank 1 when ppuA12=1. Each unit is 4 KiB.
- R10: ciramA10 follows control bits 1:0. 0 gives 0, 1 gives 1, 2 (vertical) gives ppuA10, 3 (horizontal) gives ppuA11.
- R11: wramEn is 1 exactly when cpuAddrHi = 3'b011, which is $6000-$7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-cycle clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWrEn | input | 1 | CPU write strobe, one cycle per write |
| cpuAddrHi | input | 3 | CPU address bits 15:13 |
| cpuDataLsb | input | 1 | CPU data bit 0, the serial bit |
| cpuDataMsb | input | 1 | CPU data bit 7, the reset request |
| ppuA10 | input | 1 | PPU address bit 10 |
| ppuA11 | input | 1 | PPU address bit 11 |
| ppuA12 | input | 1 | PPU address bit 12 |
| prgAddrHi | output | PRG_BANK_W | Program ROM address bits from A14 upward |
| chrAddrHi | output | CHR_BANK_W | Character ROM address bits from A12 upward |
| wramEn | output | 1 | Work RAM enable |
| ciramA10 | output | 1 | Nametable RAM bank select |

## Verification
Any wrong internal state shows up on an output within one cycle after the write that caused it. This is because all outputs are combinational on the committed registers. A miscounted shift stage is different: it stays hidden until the next commit. It then shows up as a wrong bank value, or as a value landing in the wrong register, on the prgAddrHi, chrAddrHi or ciramA10 pins. A bad back-to-back filter shows up the same way, one bit out of alignment on the following commit. So the stimulus always finishes a full load and then probes every window half and both PPU halves.

// File: rtl/serial_bank_ctrl_pkg.sv
package serial_bank_ctrl_pkg;
  localparam int REG_W = 5;

  typedef enum logic [1:0] {
    TGT_CTRL = 2'd0,
    TGT_CHR0 = 2'd1,
    TGT_CHR1 = 2'd2,
    TGT_PRG  = 2'd3
  } target_e;

  typedef struct packed {
    logic    shiftIn;
    logic    clearAll;
    logic    commit;
    target_e target;
  } strobe_t;
endpackage

// File: rtl/serial_bank_ctrl_seq.sv
module serial_bank_ctrl_seq
  import serial_bank_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuWrEn,
  input  logic [2:0] cpuAddrHi,
  input  logic       cpuDataMsb,
  output strobe_t    strobes
);
  localparam int CNT_W = $clog2(REG_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REG_W - 1);

  logic [CNT_W-1:0] cntQ;
  logic             blockQ;
  logic             mapWr, accepted;

  assign mapWr    = cpuWrEn && cpuAddrHi[2];
  assign accepted = mapWr && !blockQ;

  always_comb begin
    strobes.clearAll = accepted && cpuDataMsb;
    strobes.shiftIn  = accepted && !cpuDataMsb;
    strobes.commit   = strobes.shiftIn && (cntQ == LAST);
    strobes.target   = target_e'(cpuAddrHi[1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= '0;
      blockQ <= 1'b0;
    end else begin
      blockQ <= accepted;
      if (strobes.clearAll || strobes.commit) cntQ <= '0;
      else if (strobes.shiftIn)                cntQ <= cntQ + 1'b1;
    end
  end
endmodule

// File: rtl/serial_bank_ctrl_dp.sv
module serial_bank_ctrl_dp
  import serial_bank_ctrl_pkg::*;
#(
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobes,
  input  logic                  cpuDataLsb,
  input  logic [2:0]            cpuAddrHi,
  input  logic                  ppuA10,
  input  logic                  ppuA11,
  input  logic                  ppuA12,
  output logic [PRG_BANK_W-1:0] prgAddrHi,
  output logic [CHR_BANK_W-1:0] chrAddrHi,
  output logic                  wramEn,
  output logic                  ciramA10
);
  localparam logic [3:0] CTRL_RESET = 4'b1100;

  logic [REG_W-2:0]      shiftQ;
  logic [REG_W-1:0]      commitVal;
  logic [3:0]            ctrlQ;
  logic [CHR_BANK_W-1:0] chrQ [2];
  logic [PRG_BANK_W-1:0] prgQ;
  logic                  cpuA14;

  assign commitVal = {cpuDataLsb, shiftQ};
  assign cpuA14    = cpuAddrHi[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ  <= '0;
      ctrlQ   <= CTRL_RESET;
      chrQ[0] <= '0;
      chrQ[1] <= '0;
      prgQ    <= '0;
    end else if (strobes.clearAll) begin
      shiftQ     <= '0;
      ctrlQ[3:2] <= 2'b11;
    end else if (strobes.commit) begin
      shiftQ <= '0;
      unique case (strobes.target)
        TGT_CTRL: ctrlQ   <= commitVal[3:0];
        TGT_CHR0: chrQ[0] <= commitVal[CHR_BANK_W-1:0];
        TGT_CHR1: chrQ[1] <= commitVal[CHR_BANK_W-1:0];
        TGT_PRG:  prgQ    <= commitVal[PRG_BANK_W-1:0];
      endcase
    end else if (strobes.shiftIn) begin
      shiftQ <= {cpuDataLsb, shiftQ[REG_W-2:1]};
    end
  end

  always_comb begin
    if (!ctrlQ[3])     prgAddrHi = {prgQ[PRG_BANK_W-1:1], cpuA14};
    else if (ctrlQ[2]) prgAddrHi = cpuA14 ? '1 : prgQ;
    else               prgAddrHi = cpuA14 ? prgQ : '0;
  end

  assign chrAddrHi = ppuA12 ? chrQ[1] : chrQ[0];
  assign wramEn    = (cpuAddrHi == 3'b011);

  always_comb begin
    unique case (ctrlQ[1:0])
      2'd0: ciramA10 = 1'b0;
      2'd1: ciramA10 = 1'b1;
      2'd2: ciramA10 = ppuA10;
      2'd3: ciramA10 = ppuA11;
    endcase
  end
endmodule

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl
  import serial_bank_ctrl_pkg::*;
#(
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cpuWrEn,
  input  logic [2:0]            cpuAddrHi,
  input  logic                  cpuDataLsb,
  input  logic                  cpuDataMsb,
  input  logic                  ppuA10,
  input  logic                  ppuA11,
  input  logic                  ppuA12,
  output logic [PRG_BANK_W-1:0] prgAddrHi,
  output logic [CHR_BANK_W-1:0] chrAddrHi,
  output logic                  wramEn,
  output logic                  ciramA10
);
  strobe_t strobes;

  serial_bank_ctrl_seq u_seq (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuAddrHi(cpuAddrHi),
    .cpuDataMsb(cpuDataMsb), .strobes(strobes)
  );

  serial_bank_ctrl_dp #(.PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuDataLsb(cpuDataLsb),
    .cpuAddrHi(cpuAddrHi), .ppuA10(ppuA10), .ppuA11(ppuA11), .ppuA12(ppuA12),
    .prgAddrHi(prgAddrHi), .chrAddrHi(chrAddrHi), .wramEn(wramEn),
    .ciramA10(ciramA10)
  );
endmodule

// File: rtl/serial_bank_ctrl_chk.sv
module serial_bank_ctrl_chk
  import serial_bank_ctrl_pkg::*;
#(
  parameter int PRG_BANK_W = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input strobe_t               strobes,
  input logic [2:0]            cpuAddrHi,
  input logic [PRG_BANK_W-1:0] prgAddrHi
);
  logic [3:0] chkCnt;

  always_ff @(posedge clk) begin
    if (!rstN) chkCnt <= '0;
    else if (strobes.clearAll || strobes.commit) chkCnt <= '0;
    else if (strobes.shiftIn) chkCnt <= chkCnt + 1'b1;
  end

  // R2: a commit only happens on the fifth bit since the last commit or clear
  assert_commit_on_fifth_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> (chkCnt == 4'(REG_W - 1)));

  // R2: the shift count never runs past the register width
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    chkCnt < 4'(REG_W));

  // R5: an accepted write blocks any write action in the next cycle
  assert_drop_adjacent_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shiftIn || strobes.clearAll) |=> !(strobes.shiftIn || strobes.clearAll));

  // R4: a shift and a clear never occur in the same cycle
  assert_clear_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.shiftIn, strobes.clearAll}));

  // R4 and R7: after a clear, the upper window shows the last bank
  assert_clear_fixes_last_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> (!cpuAddrHi[1] || (&prgAddrHi)));
endmodule

bind serial_bank_ctrl serial_bank_ctrl_chk #(.PRG_BANK_W(PRG_BANK_W)) u_chk (
  .clk(clk), .rstN(rstN), .strobes(strobes), .cpuAddrHi(cpuAddrHi),
  .prgAddrHi(prgAddrHi)
);

// File: tb/serial_bank_ctrl_bench.sv
module serial_bank_ctrl_bench;
  localparam int PW = 4;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuWrEn = 1'b0;
  logic [2:0]    cpuAddrHi = 3'b000;
  logic          cpuDataLsb = 1'b0;
  logic          cpuDataMsb = 1'b0;
  logic          ppuA10 = 1'b0, ppuA11 = 1'b0, ppuA12 = 1'b0;
  logic [PW-1:0] prgAddrHi;
  logic [CW-1:0] chrAddrHi;
  logic          wramEn, ciramA10;

  int errors = 0;
  int checks = 0;

  // bench model of the committed registers
  logic [3:0] mCtrl;
  logic [4:0] mChr0, mChr1, mPrg;

  always #2.5 clk = ~clk;

  serial_bank_ctrl #(.PRG_BANK_W(PW), .CHR_BANK_W(CW)) u_serial_bank_ctrl (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuAddrHi(cpuAddrHi),
    .cpuDataLsb(cpuDataLsb), .cpuDataMsb(cpuDataMsb), .ppuA10(ppuA10),
    .ppuA11(ppuA11), .ppuA12(ppuA12), .prgAddrHi(prgAddrHi),
    .chrAddrHi(chrAddrHi), .wramEn(wramEn), .ciramA10(ciramA10)
  );

  function automatic logic [PW-1:0] expPrg(input logic a14);
    logic [PW-1:0] b = mPrg[PW-1:0];
    if (!mCtrl[3])     return {b[PW-1:1], a14};
    else if (mCtrl[2]) return a14 ? {PW{1'b1}} : b;
    else               return a14 ? b : {PW{1'b0}};
  endfunction

  function automatic logic expMir(input logic a10, input logic a11);
    case (mCtrl[1:0])
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return a10;
      default: return a11;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one accepted-or-not write cycle, followed by one idle cycle
  task automatic busWrite(input logic [2:0] a, input logic lsb, input logic msb);
    @(negedge clk);
    cpuWrEn = 1'b1; cpuAddrHi = a; cpuDataLsb = lsb; cpuDataMsb = msb;
    @(negedge clk);
    cpuWrEn = 1'b0; cpuDataMsb = 1'b0;
  endtask

  task automatic loadReg(input logic [1:0] tgt, input logic [4:0] v);
    for (int i = 0; i < 5; i++) busWrite({1'b1, tgt}, v[i], 1'b0);
    case (tgt)
      2'd0: mCtrl = v[3:0];
      2'd1: mChr0 = v;
      2'd2: mChr1 = v;
      default: mPrg = v;
    endcase
  endtask

  task automatic probeAll(input string req);
    for (int h = 0; h < 2; h++) begin
      @(negedge clk); cpuAddrHi = {1'b1, h[0], 1'b0}; #1;
      check({req, " prg"}, prgAddrHi, expPrg(h[0]));
      ppuA12 = h[0]; #1;
      check({req, " chr R9"}, chrAddrHi, h[0] ? mChr1[CW-1:0] : mChr0[CW-1:0]);
    end
    for (int m = 0; m < 4; m++) begin
      ppuA10 = m[0]; ppuA11 = m[1]; #1;
      check({req, " mirror R10"}, ciramA10, expMir(m[0], m[1]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h0bad5eed));
    mCtrl = 4'b1100; mChr0 = 0; mChr1 = 0; mPrg = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    probeAll("R1 reset");

    // R11 work RAM decode over all eight address slices
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); cpuAddrHi = a[2:0]; #1;
      check("R11 wram", wramEn, a == 3);
    end

    // R3, R9 directed targets
    loadReg(2'd1, 5'b10110);
    loadReg(2'd2, 5'b01001);
    loadReg(2'd3, 5'b00101);
    probeAll("R3 R7 targets");

    // R8 and R6 layouts
    loadReg(2'd0, 5'b01010);
    probeAll("R8 layout");
    loadReg(2'd0, 5'b00011);
    probeAll("R6 layout");

    // R2 writes below $8000 do not shift
    busWrite(3'b011, 1'b1, 1'b0);
    busWrite(3'b000, 1'b1, 1'b0);
    loadReg(2'd3, 5'b01110);
    probeAll("R2 low writes ignored");

    // R4 reset write mid-load: control bits 1:0 kept, 3:2 forced
    busWrite(3'b111, 1'b1, 1'b0);
    busWrite(3'b111, 1'b1, 1'b0);
    busWrite(3'b100, 1'b0, 1'b1);
    mCtrl[3:2] = 2'b11;
    probeAll("R4 reset write");
    loadReg(2'd1, 5'b00011);
    probeAll("R4 count cleared");

    // R5 back-to-back: second write in adjacent cycle dropped
    @(negedge clk);
    cpuWrEn = 1'b1; cpuAddrHi = 3'b110; cpuDataLsb = 1'b1;
    @(negedge clk);
    cpuDataLsb = 1'b0;
    @(negedge clk);
    cpuWrEn = 1'b0;
    for (int i = 1; i < 5; i++) busWrite(3'b110, i[0], 1'b0);
    mChr1 = 5'b01011;
    probeAll("R5 adjacent dropped");

    // R5 reset followed by adjacent zero write (double write pattern)
    @(negedge clk);
    cpuWrEn = 1'b1; cpuAddrHi = 3'b111; cpuDataLsb = 1'b1; cpuDataMsb = 1'b1;
    @(negedge clk);
    cpuDataLsb = 1'b0; cpuDataMsb = 1'b0;
    @(negedge clk);
    cpuWrEn = 1'b0;
    mCtrl[3:2] = 2'b11;
    loadReg(2'd3, 5'b11001);
    probeAll("R5 after reset write");

    // constrained random loads with interleaved non-mapper writes
    for (int n = 0; n < 40; n++) begin
      logic [1:0] tgt = 2'($urandom_range(0, 3));
      logic [4:0] v   = 5'($urandom);
      if ($urandom_range(0, 3) == 0) busWrite(3'($urandom_range(0, 3)), 1'($urandom), 1'b0);
      loadReg(tgt, v);
      probeAll("R2 R3 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule